// File: doc/BRIEF.md
# Serial Receive Segment Encoder

This block sits on the PHY side of a serial media independent link and turns one port's receive information into a continuous train of ten-bit segments on a single data line. A companion strobe pulses at the first bit of every segment, so the far end can frame the stream without recovering any other timing. Both the data line and the strobe come from this side, clocked by the same receive clock that travels to the MAC.

A segment whose second bit is 1 carries a received frame byte, taken from an upstream valid/ready byte stream. When no byte is taken, the segment carries a status byte assembled from the port's level status pins and from two flags latched over the frame that just ended: whether any of its bytes was flagged in error, and whether the upper nibble of its final byte was valid. At 100 Mbps a new byte may enter in every segment. At 10 Mbps each byte is repeated over `SLOW_REPEAT` consecutive segments.

The upstream rules are these. `in_ready` is high for one clock, the last clock of a segment, whenever the encoder can take a fresh byte. A byte is transferred when `in_valid` and `in_ready` are both high at a rising edge. If `in_valid` is low in that slot, the next segment is a status segment. `in_err` and the nibble-validity pin are sampled only with a transferred byte. The serial output has no back-pressure.

Top module: `serial_rx_seg_encoder`

## Requirements
- R1: `ser_sync` is high for exactly one clock in every 10, including the first clock after reset, and marks bit 0 of each segment.
- R2: Segment bits are sent one per clock in this order: carrier, data-valid flag, then byte bits 0 to 7.
- R3: The carrier bit of each segment is `rx_crs` as sampled on the last clock of the preceding segment.
- R4: A transferred byte produces a segment whose data-valid bit is 1 and whose bits 2 to 9 are that byte, least significant bit first.
- R5: A status segment has data-valid bit 0 and status byte bits: 0 frame error, 1 speed (1 = 100 Mbps), 2 duplex (1 = full), 3 link (1 = up), 4 jabber (1 = fault), 5 last-nibble valid, 6 false carrier (1 = seen), 7 constant 1; the level pins are sampled at the segment's load.
- R6: The status error flag is the OR of `in_err` over every byte of the most recently completed frame. It is cleared only when the first byte of the next frame is taken, and `in_err` has no effect while no byte is transferred.
- R7: The status nibble flag equals `st_nib_ok` as sampled with the last byte of the most recent frame.
- R8: `in_ready` is high only on the last clock of a segment; at 100 Mbps it is high in every segment.
- R9: At 10 Mbps a transferred byte is sent in `SLOW_REPEAT` consecutive data segments, and `in_ready` stays low during the repeats.
- R10: After reset, the first segment is all zero except byte bit 7, i.e. carrier 0, data-valid 0, status byte 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, also forwarded to the MAC |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream byte is present |
| in_ready | output | 1 | Encoder takes a byte at this edge |
| in_data | input | 8 | Received frame byte |
| in_err | input | 1 | Byte carries a receive error |
| rx_crs | input | 1 | Carrier sense level |
| st_spd100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| st_full_dup | input | 1 | 1 = full duplex |
| st_link_up | input | 1 | 1 = link up |
| st_jabber | input | 1 | 1 = jabber fault |
| st_false_car | input | 1 | 1 = false carrier seen |
| st_nib_ok | input | 1 | Upper nibble of the current byte is valid |
| ser_data | output | 1 | Serial segment bit |
| ser_sync | output | 1 | Segment start strobe |

## Verification
The bench builds the encoder with `SLOW_REPEAT` at its default of 10. This makes one low-speed byte last 100 clocks, so several 10 Mbps and 100 Mbps frames, with the gaps between them, fit into one short run. Within that run the bench can observe the repeat count ending and the frame flags surviving a long status gap. A behavioural model predicts the strobe, the serial bit and the ready pulse on every clock. A deserialiser rebuilds whole segments so that the status fields and the repeat counts can be checked directly.

// File: rtl/seg_enc_pkg.sv
package seg_enc_pkg;
  localparam int DATA_W  = 8;
  localparam int SEG_LEN = DATA_W + 2;
  localparam int IDX_W   = $clog2(SEG_LEN);

  // status byte: bit 7 always set, then conditions down to frame error at bit 0
  function automatic logic [DATA_W-1:0] pack_status(
    input logic err, input logic spd, input logic dup, input logic link,
    input logic jab, input logic nib, input logic fc);
    return {1'b1, fc, nib, jab, link, dup, spd, err};
  endfunction
endpackage

// File: rtl/seg_slot_timer.sv
module seg_slot_timer
  import seg_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] idx,
  output logic             seg_last,
  output logic             seg_first
);
  assign seg_last  = (idx == IDX_W'(SEG_LEN - 1));
  assign seg_first = (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx <= '0;
    else if (seg_last) idx <= '0;
    else               idx <= idx + 1'b1;
  end
endmodule

// File: rtl/seg_frame_track.sv
module seg_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic idle_slot,
  input  logic in_err,
  input  logic nib_in,
  output logic err_lat,
  output logic nib_lat
);
  logic in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      err_lat  <= 1'b0;
      nib_lat  <= 1'b0;
    end else if (take) begin
      in_frame <= 1'b1;
      err_lat  <= in_frame ? (err_lat | in_err) : in_err;
      nib_lat  <= nib_in;
    end else if (idle_slot) begin
      in_frame <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_source.sv
module seg_source
  import seg_enc_pkg::*;
#(
  parameter int SLOW_REPEAT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seg_last,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               spd100,
  input  logic               crs,
  input  logic [DATA_W-1:0]  status_byte,
  output logic               in_ready,
  output logic               take,
  output logic [SEG_LEN-1:0] seg_next
);
  localparam int REP_W = $clog2(SLOW_REPEAT) + 1;

  logic [REP_W-1:0]  rep_left;
  logic [DATA_W-1:0] hold_byte;

  assign in_ready = seg_last && (rep_left == '0);
  assign take     = in_ready && in_valid;

  always_comb begin
    if (take)                 seg_next = {in_data, 1'b1, crs};
    else if (rep_left != '0)  seg_next = {hold_byte, 1'b1, crs};
    else                      seg_next = {status_byte, 1'b0, crs};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_left  <= '0;
      hold_byte <= '0;
    end else if (take) begin
      hold_byte <= in_data;
      rep_left  <= spd100 ? '0 : REP_W'(SLOW_REPEAT - 1);
    end else if (seg_last && rep_left != '0) begin
      rep_left  <= rep_left - 1'b1;
    end
  end
endmodule

// File: rtl/seg_shift.sv
module seg_shift
  import seg_enc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SEG_LEN-1:0] seg_next,
  input  logic [IDX_W-1:0]   idx,
  output logic               bit_out
);
  logic [SEG_LEN-1:0] seg_q;

  assign bit_out = seg_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seg_q <= {pack_status(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 2'b00};
    else if (load) seg_q <= seg_next;
  end
endmodule

// File: rtl/serial_rx_seg_encoder.sv
module serial_rx_seg_encoder
  import seg_enc_pkg::*;
#(
  parameter int SLOW_REPEAT = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_err,
  input  logic        rx_crs,
  input  logic        st_spd100,
  input  logic        st_full_dup,
  input  logic        st_link_up,
  input  logic        st_jabber,
  input  logic        st_false_car,
  input  logic        st_nib_ok,
  output logic        ser_data,
  output logic        ser_sync
);
  logic [IDX_W-1:0]   idx;
  logic               seg_last;
  logic               take;
  logic               err_lat, nib_lat;
  logic [DATA_W-1:0]  status_byte;
  logic [SEG_LEN-1:0] seg_next;

  seg_slot_timer u_timer (
    .clk(clk), .rst_n(rst_n), .idx(idx), .seg_last(seg_last), .seg_first(ser_sync)
  );

  assign status_byte = pack_status(err_lat, st_spd100, st_full_dup, st_link_up,
                                   st_jabber, nib_lat, st_false_car);

  seg_source #(.SLOW_REPEAT(SLOW_REPEAT)) u_src (
    .clk(clk), .rst_n(rst_n), .seg_last(seg_last), .in_valid(in_valid),
    .in_data(in_data), .spd100(st_spd100), .crs(rx_crs), .status_byte(status_byte),
    .in_ready(in_ready), .take(take), .seg_next(seg_next)
  );

  seg_frame_track u_track (
    .clk(clk), .rst_n(rst_n), .take(take), .idle_slot(in_ready && !in_valid),
    .in_err(in_err), .nib_in(st_nib_ok), .err_lat(err_lat), .nib_lat(nib_lat)
  );

  seg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(seg_last), .seg_next(seg_next),
    .idx(idx), .bit_out(ser_data)
  );
endmodule

// File: rtl/seg_enc_checks.sv
module seg_enc_checks #(
  parameter int SEG_LEN = 10
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic rx_crs,
  input logic ser_data,
  input logic ser_sync
);
  localparam int CW = $clog2(SEG_LEN);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (cnt == CW'(SEG_LEN - 1))      cnt <= '0;
    else                                   cnt <= cnt + 1'b1;
  end

  assert_sync_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sync == (cnt == '0));

  assert_ready_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> ser_sync);

  assert_crs_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(SEG_LEN - 1)) |=> (ser_data == $past(rx_crs)));

  assert_take_dv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 ser_data);

  assert_idle_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ##1 !ser_data);
endmodule

bind serial_rx_seg_encoder seg_enc_checks #(.SEG_LEN(seg_enc_pkg::SEG_LEN)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rx_crs(rx_crs), .ser_data(ser_data), .ser_sync(ser_sync)
);

// File: tb/serial_rx_seg_encoder_test.sv
module serial_rx_seg_encoder_test;
  localparam int REP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_err = 1'b0, rx_crs = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic st_spd100 = 1'b0, st_full_dup = 1'b0, st_link_up = 1'b0;
  logic st_jabber = 1'b0, st_false_car = 1'b0, st_nib_ok = 1'b0;
  logic in_ready, ser_data, ser_sync;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  serial_rx_seg_encoder #(.SLOW_REPEAT(REP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_err(in_err), .rx_crs(rx_crs), .st_spd100(st_spd100),
    .st_full_dup(st_full_dup), .st_link_up(st_link_up), .st_jabber(st_jabber),
    .st_false_car(st_false_car), .st_nib_ok(st_nib_ok),
    .ser_data(ser_data), .ser_sync(ser_sync)
  );

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_pos = 0, m_rep = 0;
  bit m_inf = 0, m_err = 0, m_nib = 0;
  bit [7:0] m_hold = 0;
  bit [9:0] m_seg = 10'h200;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_rep = 0; m_inf = 0; m_err = 0; m_nib = 0; m_hold = 0;
      m_seg = 10'h200;
    end else if (m_pos == 9) begin
      if (m_rep == 0 && in_valid) begin
        m_seg  = {in_data, 1'b1, rx_crs};
        m_hold = in_data;
        m_err  = m_inf ? (m_err | in_err) : in_err;
        m_nib  = st_nib_ok;
        m_inf  = 1;
        m_rep  = st_spd100 ? 0 : REP - 1;
      end else if (m_rep != 0) begin
        m_seg = {m_hold, 1'b1, rx_crs};
        m_rep--;
      end else begin
        m_seg = {1'b1, st_false_car, m_nib, st_jabber, st_link_up, st_full_dup,
                 st_spd100, m_err, 1'b0, rx_crs};
        m_inf = 0;
      end
      m_pos = 0;
    end else begin
      m_pos++;
    end
  end

  // per-clock comparison and segment deserialiser
  int dpos = 10;
  bit [9:0] cur = 0, last_status = 0, first_data = 0, first_seg = 0;
  bit got_first = 0, want_data = 0;
  int ndata = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ser_sync == (m_pos == 0), "R1 sync strobe", ser_sync, m_pos == 0);
      chk(ser_data == m_seg[m_pos], "R2 serial bit", ser_data, m_seg[m_pos]);
      chk(in_ready == (m_pos == 9 && m_rep == 0), "R8 ready slot", in_ready,
          (m_pos == 9 && m_rep == 0));
      if (ser_sync) dpos = 0;
      if (dpos < 10) begin
        cur[dpos] = ser_data;
        dpos++;
        if (dpos == 10) begin
          if (!got_first) begin first_seg = cur; got_first = 1; end
          if (cur[1]) begin
            ndata++;
            if (want_data) begin first_data = cur; want_data = 0; end
          end else last_status = cur;
        end
      end
    end
  end

  task automatic put(input logic [7:0] b, input logic e, input logic n);
    in_valid = 1'b1; in_data = b; in_err = e; st_nib_ok = n;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_err = 1'b0;
  endtask

  task automatic gap(input int segs);
    repeat (segs * 10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gap(2);
    // R10: reset segment
    chk(first_seg == 10'h200, "R10 reset segment", first_seg, 10'h200);

    st_spd100 = 1; st_full_dup = 1; st_link_up = 1;
    gap(3);
    // R5: status field layout
    chk(last_status == 10'b1000111000, "R5 status layout", last_status, 10'b1000111000);

    // 100 Mbps frame with an error in the middle and a bad final nibble
    rx_crs = 1; want_data = 1;
    put(8'h11, 0, 1); put(8'h12, 0, 1); put(8'h13, 1, 1); put(8'h14, 0, 1); put(8'h15, 0, 0);
    rx_crs = 0;
    gap(4);
    chk(first_data == {8'h11, 2'b11}, "R4 data segment", first_data, {8'h11, 2'b11});
    chk(first_data[0] == 1'b1, "R3 carrier bit in data", first_data[0], 1);
    chk(last_status[2] == 1'b1, "R6 error flag after frame", last_status[2], 1);
    chk(last_status[7] == 1'b0, "R7 nibble flag after frame", last_status[7], 0);
    chk(last_status[0] == 1'b0, "R3 carrier bit in gap", last_status[0], 0);

    st_jabber = 1; st_false_car = 1; in_err = 1;  // in_err with no transfer: ignored
    gap(3);
    chk(last_status[6] == 1'b1, "R5 jabber bit", last_status[6], 1);
    chk(last_status[8] == 1'b1, "R5 false carrier bit", last_status[8], 1);
    chk(last_status[2] == 1'b1, "R6 error flag held", last_status[2], 1);
    st_jabber = 0; st_false_car = 0;

    // clean frame clears the error flag; good final nibble
    put(8'hC3, 0, 0); put(8'h3C, 0, 1);
    in_err = 1;
    gap(4);
    chk(last_status[2] == 1'b0, "R6 error flag cleared", last_status[2], 0);
    chk(last_status[7] == 1'b1, "R7 nibble flag good", last_status[7], 1);

    // 10 Mbps frame: each byte repeated
    in_err = 0; st_spd100 = 0;
    gap(2);
    ndata = 0; want_data = 1;
    put(8'h5A, 0, 1); put(8'hA5, 0, 1);
    gap(14);
    chk(ndata == 2 * REP, "R9 repeat count", ndata, 2 * REP);
    chk(first_data == {8'h5A, 2'b10}, "R9 repeated byte", first_data, {8'h5A, 2'b10});
    chk(last_status[3] == 1'b0, "R5 speed bit low", last_status[3], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule